// File: doc/BRIEF.md
# Reset Time-out Sequencer

This block keeps a processor core in reset after power comes up, after a sustained supply sag, and while the external reset pin is low. It releases the core only after a chain of delays has run out. The first delay is a power-up wait counted in ticks of a slow timebase. The second is an oscillator settling count made of oscillator clock enables, and it runs only when the clock comes from a crystal or resonator. A wake request from sleep reuses the oscillator settling count. At the end it gives a one-cycle release strobe and leaves the core reset untouched.

The supply-good flag and the pin each pass through a synchronizer and then a persistence filter. A supply sag counts only if it lasts for a qualification window. A pin pulse counts only if it lasts for a filter window. A cause register shows which event came last. Power-on loads it, the other events overwrite it, and a clear input empties it. A pin-drive output is asserted while a power event holds the core, and a watchdog reset never asserts it.

Top module: `rst_timeout_seq`

## Requirements
- R1: While `por_i` is high, `core_rst_o` and `pin_drive_o` are 1, `wake_rel_o` is 0 and `cause_o` is 5'b00001.
- R2: After a power-on or brown-out, the power-up wait of `PWRT_TICKS` ticks is applied when `cfg_pwrt_en_i` or `cfg_bor_en_i` is 1. After power-on, `core_rst_o` falls on rising edge 2 + P + O counted from the edge after `por_i` falls. P is `PWRT_TICKS` or 0, and O is `OST_CYCLES` or 0.
- R3: The settling count of `OST_CYCLES` oscillator enables applies only when `osc_mode_i` is 2'b00, 2'b01 or 2'b10 (crystal or resonator). Code 2'b11 is an external clock and skips it. It follows power-on and wake, never a brown-out recovery.
- R4: With `cfg_bor_en_i` = 1, a brown-out is declared only after `BOR_QUAL` consecutive synchronized low samples of `supply_ok_i`. A shorter sag, or any sag while `cfg_bor_en_i` = 0, leaves `core_rst_o` at 0.
- R5: During a brown-out the core stays in reset while the supply is low. After recovery a full power-up wait runs, and `core_rst_o` falls on edge P + 5 after `supply_ok_i` rises. A new brown-out during the wait restarts it, and this includes one qualified in the same cycle the wait would end.
- R6: A low pulse on `pin_n_i` shorter than `PIN_FILT` samples is ignored.
- R7: The delays keep counting while the pin is held low. When the pin is released after they have expired, `core_rst_o` falls on the 4th rising edge.
- R8: A one-cycle `wdt_i` pulse gives exactly one cycle of `core_rst_o` and leaves `pin_drive_o` at 0.
- R9: A one-cycle `wake_i` while running makes `wake_rel_o` pulse for one cycle, O + 1 edges later, with `core_rst_o` staying 0.
- R10: `cause_o` is one-hot: bit0 power-on, bit1 brown-out, bit2 pin, bit3 watchdog, bit4 wake. Each event loads its own bit, and `stat_clr_i` clears the register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| por_i | input | 1 | Power-on pulse, asynchronous, active high |
| supply_ok_i | input | 1 | Supply above threshold, from comparator |
| pin_n_i | input | 1 | External reset pin, active low |
| tick_i | input | 1 | Slow timebase tick enable |
| osc_en_i | input | 1 | Oscillator cycle enable |
| cfg_pwrt_en_i | input | 1 | Power-up wait enable |
| cfg_bor_en_i | input | 1 | Brown-out detection enable |
| osc_mode_i | input | 2 | Oscillator mode code |
| wake_i | input | 1 | Wake-from-sleep request |
| wdt_i | input | 1 | Watchdog reset pulse |
| stat_clr_i | input | 1 | Clears the cause register |
| core_rst_o | output | 1 | Core reset, active high |
| wake_rel_o | output | 1 | One-cycle sleep release strobe |
| pin_drive_o | output | 1 | Drives the reset pin low during power events |
| cause_o | output | 5 | One-hot last reset cause |

## Verification
Two things can happen in the same cycle. Brown-out qualification can complete on the very edge where the power-up wait counts its last tick. The bench sets this up after a recovery by lowering the supply so that the filter's hit lands exactly on the wait's final edge. A correct design gives priority to the brown-out. `core_rst_o` must then stay high on every cycle, with no one-cycle release gap. After that the next recovery must again take the full P + 5 edges.

// File: rtl/rts_pkg.sv
package rts_pkg;

   typedef enum logic [2:0] {
      ST_START,
      ST_HOLD,
      ST_PWRT,
      ST_OST,
      ST_RUN,
      ST_WOST
   } seq_st_e;

   localparam int CAUSE_W  = 5;
   localparam int CZ_POR   = 0;
   localparam int CZ_BOR   = 1;
   localparam int CZ_PIN   = 2;
   localparam int CZ_WDT   = 3;
   localparam int CZ_WAKE  = 4;

   localparam logic [1:0] MODE_EXT = 2'b11;

   function automatic logic [CAUSE_W-1:0] cause_bit(input int idx);
      logic [CAUSE_W-1:0] v;
      v = '0;
      v[idx] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/rts_sync.sv
module rts_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic          clk_i,
   input  logic          rst_i,
   input  logic [W-1:0]  d_i,
   output logic [W-1:0]  q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rts_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] pipe_q;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) pipe_q <= {STAGES{RST_VAL}};
      else       pipe_q <= {pipe_q[STAGES-2:0], d_i};
   end

   assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/rts_persist.sv
module rts_persist #(
   parameter int LEN = 4
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic lvl_i,
   output logic hit_o
);

   localparam int CW = (LEN < 2) ? 1 : $clog2(LEN);

   if (LEN < 2) begin : g_bad_len
      $error("rts_persist: LEN must be at least 2");
   end

   logic [CW-1:0] cnt_q;
   logic          hit_q;

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i) begin
         cnt_q <= '0;
         hit_q <= 1'b0;
      end else if (!lvl_i) begin
         cnt_q <= '0;
         hit_q <= 1'b0;
      end else if (cnt_q == CW'(LEN-1)) begin
         hit_q <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign hit_o = hit_q;

   // R4 and R6 share this filter
   p_qualified_r4: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(hit_q) |-> $past(lvl_i));
   p_drop_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      !lvl_i |=> !hit_o);

endmodule

// File: rtl/rts_delay.sv
module rts_delay #(
   parameter int LIMIT = 16
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic clr_i,
   input  logic en_i,
   output logic done_o
);

   localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

   if (LIMIT < 2) begin : g_bad_limit
      $error("rts_delay: LIMIT must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   assign done_o = en_i && (cnt_q == CW'(LIMIT-1));

   always_ff @(posedge clk_i or posedge rst_i) begin
      if (rst_i)        cnt_q <= '0;
      else if (clr_i)   cnt_q <= '0;
      else if (done_o)  cnt_q <= '0;
      else if (en_i)    cnt_q <= cnt_q + 1'b1;
   end

   p_wrap_r2: assert property (@(posedge clk_i) disable iff (rst_i)
      (done_o && !clr_i) |=> (cnt_q == '0));

endmodule

// File: rtl/rst_timeout_seq.sv
module rst_timeout_seq
   import rts_pkg::*;
#(
   parameter int PWRT_TICKS  = 72,
   parameter int OST_CYCLES  = 1024,
   parameter int BOR_QUAL    = 100,
   parameter int PIN_FILT    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk_i,
   input  logic                por_i,
   input  logic                supply_ok_i,
   input  logic                pin_n_i,
   input  logic                tick_i,
   input  logic                osc_en_i,
   input  logic                cfg_pwrt_en_i,
   input  logic                cfg_bor_en_i,
   input  logic [1:0]          osc_mode_i,
   input  logic                wake_i,
   input  logic                wdt_i,
   input  logic                stat_clr_i,
   output logic                core_rst_o,
   output logic                wake_rel_o,
   output logic                pin_drive_o,
   output logic [CAUSE_W-1:0]  cause_o
);

   if (PWRT_TICKS < 2 || OST_CYCLES < 2 || BOR_QUAL < 2) begin : g_bad_cfg
      $error("rst_timeout_seq: delay parameters must be at least 2");
   end

   // ---------------- input conditioning ----------------
   logic [1:0] sync_q;
   logic       supply_s, pin_s;

   rts_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
      .clk_i (clk_i),
      .rst_i (por_i),
      .d_i   ({supply_ok_i, pin_n_i}),
      .q_o   (sync_q)
   );
   assign supply_s = sync_q[1];
   assign pin_s    = sync_q[0];

   logic bor_hit, bor_det;

   rts_persist #(.LEN(BOR_QUAL)) u_bor_qual (
      .clk_i (clk_i),
      .rst_i (por_i),
      .lvl_i (~supply_s),
      .hit_o (bor_hit)
   );
   assign bor_det = bor_hit & cfg_bor_en_i;

   logic pin_lo;

   if (PIN_FILT >= 2) begin : g_pin_filt
      rts_persist #(.LEN(PIN_FILT)) u_pin_filt (
         .clk_i (clk_i),
         .rst_i (por_i),
         .lvl_i (~pin_s),
         .hit_o (pin_lo)
      );
   end else begin : g_pin_raw
      logic pin_lo_q;
      always_ff @(posedge clk_i or posedge por_i) begin
         if (por_i) pin_lo_q <= 1'b0;
         else       pin_lo_q <= ~pin_s;
      end
      assign pin_lo = pin_lo_q;
   end

   // ---------------- sequencer ----------------
   seq_st_e state_q, state_d;
   logic    por_origin_q;
   logic    pwrt_done, ost_done, ost_act;
   logic    pwrt_need, crystal;
   logic    wake_go, wake_fin, power_busy;

   assign pwrt_need  = cfg_pwrt_en_i | cfg_bor_en_i;
   assign crystal    = (osc_mode_i != MODE_EXT);
   assign ost_act    = (state_q == ST_OST) || (state_q == ST_WOST);
   assign power_busy = (state_q == ST_START) || (state_q == ST_HOLD) ||
                       (state_q == ST_PWRT)  || (state_q == ST_OST);

   rts_delay #(.LIMIT(PWRT_TICKS)) u_pwrt (
      .clk_i  (clk_i),
      .rst_i  (por_i),
      .clr_i  (state_q != ST_PWRT),
      .en_i   (tick_i && (state_q == ST_PWRT)),
      .done_o (pwrt_done)
   );

   rts_delay #(.LIMIT(OST_CYCLES)) u_ost (
      .clk_i  (clk_i),
      .rst_i  (por_i),
      .clr_i  (!ost_act),
      .en_i   (osc_en_i && ost_act),
      .done_o (ost_done)
   );

   always_comb begin
      state_d  = state_q;
      wake_go  = 1'b0;
      wake_fin = 1'b0;
      unique case (state_q)
         ST_START: state_d = pwrt_need ? ST_PWRT : (crystal ? ST_OST : ST_RUN);
         ST_HOLD:  if (supply_s) state_d = ST_PWRT;
         ST_PWRT:  if (pwrt_done)
                      state_d = (por_origin_q && crystal) ? ST_OST : ST_RUN;
         ST_OST:   if (ost_done) state_d = ST_RUN;
         ST_RUN:   if (wake_i) begin
                      wake_go = 1'b1;
                      if (crystal) state_d = ST_WOST;
                      else         wake_fin = 1'b1;
                   end
         ST_WOST:  if (ost_done) begin
                      state_d  = ST_RUN;
                      wake_fin = 1'b1;
                   end
         default:  state_d = ST_START;
      endcase
      if (bor_det) begin
         state_d  = ST_HOLD;
         wake_go  = 1'b0;
         wake_fin = 1'b0;
      end
   end

   // ---------------- registered outputs ----------------
   logic                core_rst_q, wake_rel_q, pin_lo_d;
   logic                pin_rise;
   logic [CAUSE_W-1:0]  cause_q;

   assign pin_rise = pin_lo & ~pin_lo_d;

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i) begin
         state_q      <= ST_START;
         por_origin_q <= 1'b1;
         core_rst_q   <= 1'b1;
         wake_rel_q   <= 1'b0;
         pin_lo_d     <= 1'b0;
         cause_q      <= cause_bit(CZ_POR);
      end else begin
         state_q    <= state_d;
         core_rst_q <= power_busy | pin_lo | wdt_i;
         wake_rel_q <= wake_fin;
         pin_lo_d   <= pin_lo;
         if (bor_det) por_origin_q <= 1'b0;
         if (bor_det)          cause_q <= cause_bit(CZ_BOR);
         else if (pin_rise)    cause_q <= cause_bit(CZ_PIN);
         else if (wdt_i)       cause_q <= cause_bit(CZ_WDT);
         else if (wake_go)     cause_q <= cause_bit(CZ_WAKE);
         else if (stat_clr_i)  cause_q <= '0;
      end
   end

   assign core_rst_o  = core_rst_q;
   assign wake_rel_o  = wake_rel_q;
   assign pin_drive_o = power_busy;
   assign cause_o     = cause_q;

   // ---------------- assertions ----------------
   p_pwrt_forced_r2: assert property (@(posedge clk_i) disable iff (por_i)
      (state_q == ST_START && cfg_bor_en_i && !bor_hit) |=> (state_q == ST_PWRT));
   p_ost_mode_r3: assert property (@(posedge clk_i) disable iff (por_i)
      $rose(state_q == ST_OST) |-> $past(crystal && por_origin_q));
   p_bor_restart_r5: assert property (@(posedge clk_i) disable iff (por_i)
      (cfg_bor_en_i && bor_hit) |=> (state_q == ST_HOLD));
   p_hold_keep_r5: assert property (@(posedge clk_i) disable iff (por_i)
      (state_q == ST_HOLD && !supply_s) |=> (state_q == ST_HOLD));
   p_pin_release_r7: assert property (@(posedge clk_i) disable iff (por_i)
      (!pin_lo && pin_lo_d && !power_busy && !wdt_i) |=> !core_rst_o);
   p_wdt_nodrive_r8: assert property (@(posedge clk_i) disable iff (por_i)
      (state_q == ST_RUN && wdt_i && !bor_det) |=> !pin_drive_o);
   p_wake_src_r9: assert property (@(posedge clk_i) disable iff (por_i)
      wake_rel_o |-> $past(state_q == ST_RUN || state_q == ST_WOST));
   p_cause_onehot_r10: assert property (@(posedge clk_i) disable iff (por_i)
      $onehot0(cause_q));

endmodule

// File: tb/sim_rst_timeout_seq.sv
module sim_rst_timeout_seq;

   localparam int P = 20;
   localparam int O = 16;
   localparam int Q = 6;
   localparam int F = 3;

   // {mode[1:0], pwrt_en, bor_en, expected release edge[5:0]}
   localparam logic [9:0] VEC [8] = '{
      {2'd0, 1'b0, 1'b0, 6'd18},
      {2'd1, 1'b1, 1'b0, 6'd38},
      {2'd2, 1'b0, 1'b1, 6'd38},
      {2'd3, 1'b1, 1'b0, 6'd22},
      {2'd3, 1'b0, 1'b0, 6'd2},
      {2'd3, 1'b0, 1'b1, 6'd22},
      {2'd2, 1'b1, 1'b1, 6'd38},
      {2'd1, 1'b0, 1'b0, 6'd18}
   };

   logic       clk = 1'b0;
   logic       por = 1'b1;
   logic       supply_ok = 1'b1;
   logic       pin_n = 1'b1;
   logic       tick = 1'b1;
   logic       osc_en = 1'b1;
   logic       cfg_pwrt = 1'b0;
   logic       cfg_bor = 1'b0;
   logic [1:0] mode = 2'b11;
   logic       wake = 1'b0;
   logic       wdt = 1'b0;
   logic       stat_clr = 1'b0;
   logic       core_rst, wake_rel, pin_drive;
   logic [4:0] cause;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   rst_timeout_seq #(
      .PWRT_TICKS(P), .OST_CYCLES(O), .BOR_QUAL(Q), .PIN_FILT(F), .SYNC_STAGES(2)
   ) u0 (
      .clk_i(clk), .por_i(por), .supply_ok_i(supply_ok), .pin_n_i(pin_n),
      .tick_i(tick), .osc_en_i(osc_en), .cfg_pwrt_en_i(cfg_pwrt),
      .cfg_bor_en_i(cfg_bor), .osc_mode_i(mode), .wake_i(wake), .wdt_i(wdt),
      .stat_clr_i(stat_clr), .core_rst_o(core_rst), .wake_rel_o(wake_rel),
      .pin_drive_o(pin_drive), .cause_o(cause)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_rel(input int lim, output int n);
      n = 0;
      while (core_rst && n < lim) begin
         step(1);
         n++;
      end
   endtask

   task automatic do_por(input logic [1:0] m, input logic pw, input logic bo);
      por = 1'b1;
      mode = m;
      cfg_pwrt = pw;
      cfg_bor = bo;
      step(3);
      por = 1'b0;
   endtask

   // counts cycles with core reset high (want_high=1) or low over n cycles
   task automatic watch(input int n, input logic want_high, output int cnt);
      cnt = 0;
      for (int k = 0; k < n; k++) begin
         step(1);
         if (core_rst == want_high) cnt++;
      end
   endtask

   task automatic wake_run(input int lim, output int n, output int rst_hi);
      n = 0;
      rst_hi = 0;
      wake = 1'b1;
      step(1);
      wake = 1'b0;
      n = 1;
      if (core_rst) rst_hi++;
      while (!wake_rel && n < lim) begin
         step(1);
         n++;
         if (core_rst) rst_hi++;
      end
   endtask

   task automatic finish_run;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #(4 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int n;
      int c;
      step(2);
      // R1 reset state
      chk("R1 core_rst during por", int'(core_rst), 1);
      chk("R1 pin_drive during por", int'(pin_drive), 1);
      chk("R1 wake_rel during por", int'(wake_rel), 0);
      chk("R1 cause during por", int'(cause), 1);

      // R2 / R3 release timing table
      for (int i = 0; i < 8; i++) begin
         logic [9:0] v;
         v = VEC[i];
         do_por(v[9:8], v[7], v[6]);
         wait_rel(200, n);
         chk($sformatf("R2 R3 release edge vector %0d", i), n, int'(v[5:0]));
      end
      chk("R10 cause after power-on", int'(cause), 1);

      // brown-out scenarios, crystal mode, bor forces power-up wait
      do_por(2'b01, 1'b0, 1'b1);
      wait_rel(200, n);
      chk("R2 forced wait release", n, 38);

      supply_ok = 1'b0; step(Q - 1); supply_ok = 1'b1;
      watch(15, 1'b1, c);
      chk("R4 short sag ignored", c, 0);
      chk("R4 short sag cause kept", int'(cause), 1);

      cfg_bor = 1'b0;
      supply_ok = 1'b0; step(20); supply_ok = 1'b1;
      watch(10, 1'b1, c);
      chk("R4 sag with detection off", c, 0);
      cfg_bor = 1'b1;

      supply_ok = 1'b0; step(30);
      chk("R5 held during low supply", int'(core_rst), 1);
      chk("R5 pin_drive during brown-out", int'(pin_drive), 1);
      chk("R10 brown-out cause", int'(cause), 2);
      supply_ok = 1'b1;
      wait_rel(200, n);
      chk("R5 R3 recovery release edge", n, P + 5);

      // sag in the middle of the power-up wait
      supply_ok = 1'b0; step(30); supply_ok = 1'b1;
      step(4);
      supply_ok = 1'b0;
      watch(10, 1'b0, c);
      supply_ok = 1'b1;
      chk("R5 no release during mid-wait sag", c, 0);
      wait_rel(200, n);
      chk("R5 restarted wait release edge", n, P + 5);

      // brown-out qualified on the last wait edge
      supply_ok = 1'b0; step(30); supply_ok = 1'b1;
      step(15);
      supply_ok = 1'b0;
      watch(20, 1'b0, c);
      chk("R5 coincident sag keeps reset", c, 0);
      chk("R10 coincident cause", int'(cause), 2);
      supply_ok = 1'b1;
      wait_rel(200, n);
      chk("R5 coincident recovery edge", n, P + 5);

      // pin filter
      pin_n = 1'b0; step(F - 1); pin_n = 1'b1;
      watch(8, 1'b1, c);
      chk("R6 short pin pulse ignored", c, 0);
      pin_n = 1'b0; step(F + 5);
      chk("R6 long pin pulse resets", int'(core_rst), 1);
      chk("R10 pin cause", int'(cause), 4);
      pin_n = 1'b1;
      step(3);
      chk("R7 still in reset at 3rd edge", int'(core_rst), 1);
      step(1);
      chk("R7 released at 4th edge", int'(core_rst), 0);

      // watchdog
      wdt = 1'b1; step(1); wdt = 1'b0;
      chk("R8 watchdog resets core", int'(core_rst), 1);
      chk("R8 watchdog leaves pin released", int'(pin_drive), 0);
      step(1);
      chk("R8 watchdog reset is one cycle", int'(core_rst), 0);
      chk("R10 watchdog cause", int'(cause), 8);

      // wake, crystal then external clock
      wake_run(100, n, c);
      chk("R9 crystal wake strobe edge", n, O + 1);
      chk("R9 core untouched by wake", c, 0);
      step(1);
      chk("R9 strobe lasts one cycle", int'(wake_rel), 0);
      chk("R10 wake cause", int'(cause), 16);
      stat_clr = 1'b1; step(1); stat_clr = 1'b0;
      chk("R10 status clear", int'(cause), 0);
      mode = 2'b11;
      wake_run(100, n, c);
      chk("R9 R3 external clock wake edge", n, 1);

      // pin held across power-on: delays expire underneath
      pin_n = 1'b0;
      do_por(2'b01, 1'b1, 1'b0);
      step(60);
      chk("R7 held pin keeps reset", int'(core_rst), 1);
      pin_n = 1'b1;
      step(3);
      chk("R7 held pin 3rd edge", int'(core_rst), 1);
      step(1);
      chk("R7 held pin release at 4th edge", int'(core_rst), 0);
      chk("R10 pin cause after power-on", int'(cause), 4);

      finish_run();
   end

endmodule